// File: doc/BRIEF.md
# Round-Robin Bus Request Arbiter for Three Masters

This block lets three internal bus masters share a single request/grant pair toward an external bus arbiter. Master 0 (bit 0 of every master vector) is the system-interface master; masters 1 and 2 (bits 1 and 2) are the two data-channel masters. Each master raises its request and holds it high until its transaction has finished.

When the block is idle and at least one master is requesting, it chooses one of them in circular order and drives the active-low external request. When the external active-low grant arrives, the grant is passed on to the chosen master only. The choice is fixed until that master lowers its request. The next search then starts at the master after it. If another master is waiting at that point, ownership passes to it directly and the external request stays asserted. If nobody is waiting, the external request is released.

Top module: `bus_req_arbiter`

## Requirements
- R1: After reset, `ext_req_n` is 1 and `mst_gnt` is 0. The first search starts at master 0, so with all three masters requesting, master 0 wins.
- R2: When idle, the winner is the first requesting master in circular order from the search pointer. `ext_req_n` goes to 0 on the first clock edge at which a request is seen.
- R3: `mst_gnt` follows `ext_gnt_n` in the same cycle. While `ext_gnt_n` is 1, every `mst_gnt` bit is 0. While it is 0, only the owner's bit may be 1.
- R4: At most one bit of `mst_gnt` is 1 at any time.
- R5: While the owner keeps its request high, ownership does not change, whatever the other masters do.
- R6: When the owner lowers its request, the next search starts at owner+1 modulo 3. If a master is found, it becomes owner at the next clock edge and `ext_req_n` stays 0.
- R7: If no master requested at a clock edge, `ext_req_n` is 1 after that edge.
- R8: A grant bit is never 1 for a master whose request is 0. An owner that lowers its request loses its grant bit in the same cycle.
- R9: A requesting master becomes owner after at most two tenures of other masters have begun, while the others keep requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_req | input | 3 | Per-master request; bit 0 system interface, bits 1 and 2 data channels |
| mst_gnt | output | 3 | Per-master forwarded grant |
| ext_req_n | output | 1 | Active-low request to the external bus arbiter |
| ext_gnt_n | input | 1 | Active-low grant from the external bus arbiter |

## Verification
A directed sequence starts with two data-channel masters requesting. This shows that the search begins at the pointer and not at a fixed priority. A third request is then added during a tenure, to show that the lock holds against competition. The external grant is toggled while one master owns the bus, which separates grant forwarding from ownership. Requests are then dropped one at a time, to separate a direct handoff from a release to idle. A continuous all-request phase, with each owner dropping for one cycle, feeds a scoreboard of the expected rotation. It also measures how many foreign tenures each master waits through.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int DEF_MASTERS = 3;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_GNT = 2'd1,
        ST_OWNED    = 2'd2
    } arb_state_e;

    function automatic int wrap_inc(input int idx, input int count);
        return (idx + 1 >= count) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int N     = arb_pkg::DEF_MASTERS,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] win
);
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < N; k++) begin
            automatic int c = int'(start) + k;
            if (c >= N) c = c - N;
            if (!found && req[c]) begin
                found = 1'b1;
                win   = IDX_W'(c);
            end
        end
    end
endmodule

// File: rtl/owner_ctrl.sv
module owner_ctrl
    import arb_pkg::*;
#(
    parameter int N     = arb_pkg::DEF_MASTERS,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             ext_gnt_n,
    input  logic             pick_found,
    input  logic [IDX_W-1:0] pick_idx,
    output logic [IDX_W-1:0] search_start,
    output logic [IDX_W-1:0] owner,
    output logic             busy,
    output logic             ext_req_n
);
    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] owner_q, owner_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [IDX_W-1:0] after_owner;

    assign after_owner  = IDX_W'(wrap_inc(int'(owner_q), N));
    assign busy         = (state_q != ST_IDLE);
    assign owner        = owner_q;
    assign search_start = busy ? after_owner : ptr_q;

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        ptr_d   = ptr_q;
        case (state_q)
            ST_IDLE: begin
                if (pick_found) begin
                    owner_d = pick_idx;
                    state_d = ST_WAIT_GNT;
                end
            end
            default: begin
                if (!req[owner_q]) begin
                    ptr_d = after_owner;
                    if (pick_found) begin
                        owner_d = pick_idx;
                        state_d = ext_gnt_n ? ST_WAIT_GNT : ST_OWNED;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (state_q == ST_WAIT_GNT && !ext_gnt_n) begin
                    state_d = ST_OWNED;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            owner_q   <= '0;
            ptr_q     <= '0;
            ext_req_n <= 1'b1;
        end else begin
            state_q   <= state_d;
            owner_q   <= owner_d;
            ptr_q     <= ptr_d;
            ext_req_n <= (state_d == ST_IDLE);
        end
    end
endmodule

// File: rtl/grant_fwd.sv
module grant_fwd #(
    parameter int N     = arb_pkg::DEF_MASTERS,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             busy,
    input  logic [IDX_W-1:0] owner,
    input  logic [N-1:0]     req,
    input  logic             ext_gnt_n,
    output logic [N-1:0]     gnt
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign gnt[i] = busy && !ext_gnt_n && req[i] && (owner == IDX_W'(i));
    end
endmodule

// File: rtl/bus_req_arbiter.sv
module bus_req_arbiter #(
    parameter int N     = arb_pkg::DEF_MASTERS,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] mst_req,
    output logic [N-1:0] mst_gnt,
    output logic         ext_req_n,
    input  logic         ext_gnt_n
);
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] search_start;
    logic [IDX_W-1:0] owner;
    logic             busy;

    rr_picker #(.N(N), .IDX_W(IDX_W)) picker_i (
        .req   (mst_req),
        .start (search_start),
        .found (pick_found),
        .win   (pick_idx)
    );

    owner_ctrl #(.N(N), .IDX_W(IDX_W)) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .req          (mst_req),
        .ext_gnt_n    (ext_gnt_n),
        .pick_found   (pick_found),
        .pick_idx     (pick_idx),
        .search_start (search_start),
        .owner        (owner),
        .busy         (busy),
        .ext_req_n    (ext_req_n)
    );

    grant_fwd #(.N(N), .IDX_W(IDX_W)) fwd_i (
        .busy      (busy),
        .owner     (owner),
        .req       (mst_req),
        .ext_gnt_n (ext_gnt_n),
        .gnt       (mst_gnt)
    );
endmodule

// File: rtl/bus_req_arbiter_chk.sv
module bus_req_arbiter_chk #(
    parameter int N     = arb_pkg::DEF_MASTERS,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic [N-1:0]     mst_req,
    input logic [N-1:0]     mst_gnt,
    input logic             ext_req_n,
    input logic             ext_gnt_n,
    input logic [IDX_W-1:0] owner,
    input logic             busy
);
    logic             past_valid;
    logic             prev_busy;
    logic [IDX_W-1:0] prev_owner;
    logic             new_tenure;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_valid <= 1'b0;
            prev_busy  <= 1'b0;
            prev_owner <= '0;
        end else begin
            past_valid <= 1'b1;
            prev_busy  <= busy;
            prev_owner <= owner;
        end
    end

    assign new_tenure = past_valid && busy && (!prev_busy || prev_owner != owner);

    AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mst_gnt)); // R4

    AST_GNT_NEEDS_EXT: assert property (@(posedge clk) disable iff (rst)
        (|mst_gnt) |-> !ext_gnt_n); // R3

    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && mst_req[owner]) |=> (busy && owner == $past(owner))); // R5

    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(mst_req) == '0) |-> ext_req_n); // R7

    for (genvar i = 0; i < N; i++) begin : g_mst
        logic [2:0] wait_cnt;

        always_ff @(posedge clk) begin
            if (rst || !mst_req[i] || (busy && owner == IDX_W'(i))) begin
                wait_cnt <= '0;
            end else if (new_tenure && wait_cnt != 3'd7) begin
                wait_cnt <= wait_cnt + 3'd1;
            end
        end

        AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
            mst_gnt[i] |-> mst_req[i]); // R8

        AST_NO_STARVE: assert property (@(posedge clk) disable iff (rst)
            wait_cnt <= 3'(N - 1)); // R9
    end
endmodule

bind bus_req_arbiter bus_req_arbiter_chk #(.N(N), .IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .mst_req   (mst_req),
    .mst_gnt   (mst_gnt),
    .ext_req_n (ext_req_n),
    .ext_gnt_n (ext_gnt_n),
    .owner     (owner),
    .busy      (busy)
);

// File: tb/bus_req_arbiter_tb_top.sv
module bus_req_arbiter_tb_top;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] mst_req;
    logic [N-1:0] mst_gnt;
    logic         ext_req_n;
    logic         ext_gnt_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit mon_en   = 1'b0;
    bit done     = 1'b0;

    int exp_q[$];
    logic [N-1:0] last_gnt;
    int tenure_cnt;
    int last_tenure [N];

    always #4 clk = ~clk;

    bus_req_arbiter #(.N(N)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .mst_req   (mst_req),
        .mst_gnt   (mst_gnt),
        .ext_req_n (ext_req_n),
        .ext_gnt_n (ext_gnt_n)
    );

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Monitor: pops the expected owner whenever a new grant appears.
    always @(negedge clk) begin
        if (mon_en && mst_gnt != '0 && mst_gnt != last_gnt) begin
            int m;
            int exp_m;
            m = 0;
            for (int i = 0; i < N; i++) if (mst_gnt[i]) m = i;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected grant", m, -1);
            end else begin
                exp_m = exp_q.pop_front();
                check(m == exp_m, "R6 rotation order", m, exp_m);
            end
            if (last_tenure[m] >= 0)
                check(tenure_cnt - last_tenure[m] - 1 <= 2, "R9 foreign tenures waited",
                      tenure_cnt - last_tenure[m] - 1, 2);
            last_tenure[m] = tenure_cnt;
            tenure_cnt++;
            last_gnt = mst_gnt;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        mst_req = '0;
        ext_gnt_n = 1'b1;
        last_gnt = '0;
        tenure_cnt = 0;
        for (int i = 0; i < N; i++) last_tenure[i] = -1;
        repeat (3) tick();
        rst = 1'b0;
        check(ext_req_n == 1'b1, "R1 ext_req_n after reset", ext_req_n, 1);
        check(mst_gnt == '0, "R1 mst_gnt after reset", mst_gnt, 0);

        // Two channel masters request; search starts at master 0 -> master 1 wins.
        mst_req = 3'b110;
        tick();
        check(ext_req_n == 1'b0, "R2 ext_req_n asserted", ext_req_n, 0);
        check(mst_gnt == '0, "R3 no grant before ext grant", mst_gnt, 0);
        ext_gnt_n = 1'b0;
        #1;
        check(mst_gnt == 3'b010, "R2 winner from pointer", mst_gnt, 3'b010);

        // Third master joins; lock must hold.
        mst_req = 3'b111;
        repeat (4) tick();
        check(mst_gnt == 3'b010, "R5 owner held", mst_gnt, 3'b010);
        ext_gnt_n = 1'b1;
        #1;
        check(mst_gnt == '0, "R3 grant follows ext grant", mst_gnt, 0);
        tick();
        ext_gnt_n = 1'b0;
        #1;
        check(mst_gnt == 3'b010, "R5 owner kept over ext toggle", mst_gnt, 3'b010);

        // Owner 1 drops: immediate grant removal, then handoff to master 2.
        mst_req = 3'b101;
        #1;
        check(mst_gnt == '0, "R8 grant removed with request", mst_gnt, 0);
        tick();
        check(mst_gnt == 3'b100, "R6 handoff to owner+1", mst_gnt, 3'b100);
        check(ext_req_n == 1'b0, "R6 ext_req_n held through handoff", ext_req_n, 0);

        // Owner 2 drops: wrap to master 0.
        mst_req = 3'b001;
        tick();
        check(mst_gnt == 3'b001, "R6 wrap to master 0", mst_gnt, 3'b001);

        // Last owner drops with nobody waiting.
        mst_req = '0;
        tick();
        check(ext_req_n == 1'b1, "R7 ext_req_n released", ext_req_n, 1);
        check(mst_gnt == '0, "R7 no grant when idle", mst_gnt, 0);

        // Reset again: pointer back at master 0, then continuous rotation.
        rst = 1'b1;
        tick();
        rst = 1'b0;
        mon_en = 1'b1;
        begin
            int e;
            e = 0;
            exp_q.push_back(0); // R1: first winner with all requesting is master 0
            mst_req = 3'b111;
            tick();
            for (int r = 0; r < 12; r++) begin
                repeat (3) tick();
                exp_q.push_back((e + 1) % N);
                mst_req[e] = 1'b0;
                tick();
                mst_req[e] = 1'b1;
                e = (e + 1) % N;
            end
            repeat (3) tick();
            mst_req = '0;
            repeat (3) tick();
        end
        mon_en = 1'b0;
        check(exp_q.size() == 0, "R6 all expected owners seen", exp_q.size(), 0);
        check(tenure_cnt == 13, "R9 tenure count", tenure_cnt, 13);
        check(ext_req_n == 1'b1, "R7 released after rotation", ext_req_n, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule